// File: doc/BRIEF.md
# Cascadable Column Data Loader

This block fills one display line of gray-scale values for a column driver that sits in a chain of identical devices. On every clock it takes one word from a 36-bit input bus. The word carries six 6-bit dot values. It writes the word into a register as wide as the whole line, at the group of six columns chosen by an internal slot pointer. A one-cycle start token arms the loader. After the loader has taken its share of the line, it passes the token on to the next device in the chain. Shortly after that it stops capturing by itself.

A direction input does two jobs. It sets whether the groups fill from the low column end or the high column end. It also sets which of the two start pins receives the token and which one sends it on. An inversion input can store every dot bit-inverted as it loads. A rising edge on the line strobe rewinds the pointer and ends any capture in progress. The full line is exposed as one flat vector, so the downstream line latch can copy it in parallel.

Top module: `col_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the line register, the slot pointer, the capture flag, both start outputs and `inv_fault` all clear to zero.
- R2: With `fill_up` high, the n-th word after the start edge lands in column group n, which covers columns 6n to 6n+5. Dot j of the word occupies bits [6j+5:6j] of the word and goes to column 6n+j, with bit 0 of each dot as its LSB.
- R3: With `fill_up` low, the n-th word lands in column group 63-n. Dot order inside the group is unchanged.
- R4: With `fill_up` high, the token is taken from `start_r_i` and sent on through `start_l_o`, and `start_l_oe` is 1 while `start_r_oe` is 0. With `fill_up` low, every one of these roles is swapped. The pin that is not selected as the input has no effect.
- R5: If the selected start input is sampled high at edge k, the bus word present at edge k+1 is stored as word 0. A start input held high for several clocks counts only once, on its rising sample.
- R6: The forwarding start output is high for exactly one cycle, set by edge k+64.
- R7: Only 64 words are written per token. Bus values at edges k+65 onward change nothing, and capture ends after edge k+66.
- R8: A rising edge of `strobe` clears the slot pointer and ends capture. The word on the bus at that edge and at later edges is not written.
- R9: While `inv_en` is high, every dot is stored bit-inverted. While it is low, dots are stored unchanged.
- R10: If `inv_en` differs from its value at the previous edge while `strobe` is high, `inv_fault` is high for the following cycle. Otherwise `inv_fault` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_up | input | 1 | 1: groups fill from column 0 upward; 0: from the top downward |
| start_r_i | input | 1 | Start token input used when fill_up is 1 |
| start_l_i | input | 1 | Start token input used when fill_up is 0 |
| start_r_o | output | 1 | Forwarded token when fill_up is 0 |
| start_l_o | output | 1 | Forwarded token when fill_up is 1 |
| start_r_oe | output | 1 | Drive enable for the right start pad |
| start_l_oe | output | 1 | Drive enable for the left start pad |
| dot_bus | input | 36 | Six 6-bit dot values, dot j in bits [6j+5:6j] |
| inv_en | input | 1 | Store dots bit-inverted when 1 |
| strobe | input | 1 | Line strobe; its rising edge rewinds the pointer |
| line_data | output | 2304 | Whole line register, column c in bits [6c+5:6c] |
| inv_fault | output | 1 | One-cycle flag for an inversion change while strobe is high |

## Verification
The hardest case to reach is a capture cut short by the strobe. The pointer has to be partway through the line, and the groups it has not yet reached must still hold known content from an earlier line. The stimulus first loads a full line. It then starts a second line with a different pattern and raises the strobe after ten words. The test then shows that only the first ten groups changed, and that the word presented on the strobe edge itself was dropped. The two clocks of tail after the 64th word are also checked: junk is driven on the bus there, and the start-output pulse is sampled on either side of edge k+64.

// File: rtl/col_ld_pkg.sv
// Shared definitions for the column data loader.
// Assumes: nothing beyond the standard language.
package col_ld_pkg;
    // Fill order selected by the direction input
    typedef enum logic {
        FILL_DOWN = 1'b0,
        FILL_UP   = 1'b1
    } fill_dir_e;

    // Default geometry of one device
    localparam int DEF_COLS  = 384;
    localparam int DEF_DOT_W = 6;
    localparam int DEF_DOTS  = 6;
endpackage

// File: rtl/col_ld_seq.sv
// Capture sequencer: detects the start token, walks the slot pointer,
// forwards the token after SLOTS clocks and stops two clocks later.
// Assumes: start inputs and strobe are synchronous to clk.
module col_ld_seq #(
    parameter int SLOTS = 64,
    localparam int PW   = $clog2(SLOTS + 1),
    localparam int STOP = SLOTS + 2,
    localparam int CW   = $clog2(STOP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_up,
    input  logic          start_r_i,
    input  logic          start_l_i,
    input  logic          strobe,
    output logic          wr_en,
    output logic [PW-1:0] slot,
    output logic          fwd
);
    logic          start_q;
    logic          strb_q;
    logic          busy;
    logic [CW-1:0] cnt;
    logic          start_sel;
    logic          start_rise;
    logic          strb_rise;

    // Select the active start pin and find rising samples
    always_comb begin
        start_sel  = fill_up ? start_r_i : start_l_i;
        start_rise = start_sel && !start_q;
        strb_rise  = strobe && !strb_q;
        wr_en      = busy && (slot < PW'(SLOTS)) && !strb_rise;
    end

    // Remember previous input levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            strb_q  <= 1'b0;
        end else begin
            start_q <= start_sel;
            strb_q  <= strobe;
        end
    end

    // Capture state: arm, advance, forward the token, stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            slot <= '0;
            fwd  <= 1'b0;
        end else if (strb_rise) begin
            busy <= 1'b0;
            cnt  <= '0;
            slot <= '0;
            fwd  <= 1'b0;
        end else if (start_rise && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
            slot <= '0;
            fwd  <= 1'b0;
        end else if (busy) begin
            cnt  <= cnt + 1'b1;
            fwd  <= (cnt == CW'(SLOTS - 1));
            if (cnt == CW'(STOP - 1)) busy <= 1'b0;
            if (slot < PW'(SLOTS)) slot <= slot + 1'b1;
        end else begin
            fwd <= 1'b0;
        end
    end

    a_r8_strobe_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        strb_rise |=> (slot == '0 && !busy));
    a_r6_fwd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |=> !fwd);
    a_r7_slot_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= PW'(SLOTS));
    a_r5_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rise && !busy && !strb_rise) |=> (busy && slot == '0));
endmodule

// File: rtl/col_ld_store.sv
// Line register: one word per column group, written at the physical
// group that the slot pointer and fill order select, optionally inverted.
// Assumes: slot < SLOTS whenever wr_en is high.
module col_ld_store #(
    parameter int SLOTS  = 64,
    parameter int WORD_W = 36,
    localparam int PW    = $clog2(SLOTS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [PW-1:0]           slot,
    input  logic                    fill_up,
    input  logic                    invert,
    input  logic [WORD_W-1:0]       word_in,
    output logic [SLOTS*WORD_W-1:0] line_out
);
    logic [PW-1:0]     phys;
    logic [WORD_W-1:0] wdata;

    // Map the logical slot onto a physical group and apply inversion
    always_comb begin
        phys  = fill_up ? slot : (PW'(SLOTS - 1) - slot);
        wdata = word_in ^ {WORD_W{invert}};
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_grp
        // Hold one column group; load it when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                line_out[g*WORD_W +: WORD_W] <= '0;
            else if (wr_en && phys == PW'(g))
                line_out[g*WORD_W +: WORD_W] <= wdata;
        end
    end

    a_r7_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (slot < PW'(SLOTS)));
endmodule

// File: rtl/col_ld_guard.sv
// Inversion guard: flags a change of the inversion input while the
// strobe is high, which would enter an illegal test mode.
// Assumes: inv_en and strobe are synchronous to clk.
module col_ld_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic inv_en,
    input  logic strobe,
    output logic inv_fault
);
    logic inv_q;

    // Track the previous inversion level and raise the fault flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q     <= 1'b0;
            inv_fault <= 1'b0;
        end else begin
            inv_q     <= inv_en;
            inv_fault <= strobe && (inv_en != inv_q);
        end
    end

    a_r10_fault_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        inv_fault |-> $past(strobe));
endmodule

// File: rtl/col_loader.sv
// Cascadable column data loader top: ties the sequencer, line register
// and inversion guard together and maps the token onto the start pins.
// Assumes: NUM_COLS is a multiple of DOTS.
module col_loader
    import col_ld_pkg::*;
#(
    parameter int NUM_COLS = DEF_COLS,
    parameter int DOT_W    = DEF_DOT_W,
    parameter int DOTS     = DEF_DOTS,
    localparam int WORD_W  = DOT_W * DOTS,
    localparam int SLOTS   = NUM_COLS / DOTS,
    localparam int PW      = $clog2(SLOTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fill_up,
    input  logic                       start_r_i,
    input  logic                       start_l_i,
    output logic                       start_r_o,
    output logic                       start_l_o,
    output logic                       start_r_oe,
    output logic                       start_l_oe,
    input  logic [WORD_W-1:0]          dot_bus,
    input  logic                       inv_en,
    input  logic                       strobe,
    output logic [NUM_COLS*DOT_W-1:0]  line_data,
    output logic                       inv_fault
);
    logic          wr_en;
    logic [PW-1:0] slot;
    logic          fwd;
    fill_dir_e     dir;

    // Decode the direction and route the forwarded token
    always_comb begin
        dir        = fill_dir_e'(fill_up);
        start_l_oe = (dir == FILL_UP);
        start_r_oe = (dir == FILL_DOWN);
        start_l_o  = (dir == FILL_UP)   && fwd;
        start_r_o  = (dir == FILL_DOWN) && fwd;
    end

    col_ld_seq #(.SLOTS(SLOTS)) u_seq (
        .clk(clk), .rst_n(rst_n), .fill_up(fill_up),
        .start_r_i(start_r_i), .start_l_i(start_l_i), .strobe(strobe),
        .wr_en(wr_en), .slot(slot), .fwd(fwd)
    );

    col_ld_store #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .slot(slot),
        .fill_up(fill_up), .invert(inv_en), .word_in(dot_bus),
        .line_out(line_data)
    );

    col_ld_guard u_guard (
        .clk(clk), .rst_n(rst_n), .inv_en(inv_en), .strobe(strobe),
        .inv_fault(inv_fault)
    );

    a_r4_token_on_out_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (start_l_o |-> start_l_oe) and (start_r_o |-> start_r_oe));
endmodule

// File: tb/tb_col_loader.sv
`timescale 1ns/1ps
module tb_col_loader;
    localparam int COLS = 384;
    localparam int WW   = 36;
    localparam int SL   = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_up = 1'b1;
    logic start_r_i = 1'b0, start_l_i = 1'b0;
    logic start_r_o, start_l_o, start_r_oe, start_l_oe;
    logic [WW-1:0] dot_bus = '0;
    logic inv_en = 1'b0, strobe = 1'b0;
    logic [COLS*6-1:0] line_data;
    logic inv_fault;

    always #10 clk = ~clk;

    col_loader dut (
        .clk(clk), .rst_n(rst_n), .fill_up(fill_up),
        .start_r_i(start_r_i), .start_l_i(start_l_i),
        .start_r_o(start_r_o), .start_l_o(start_l_o),
        .start_r_oe(start_r_oe), .start_l_oe(start_l_oe),
        .dot_bus(dot_bus), .inv_en(inv_en), .strobe(strobe),
        .line_data(line_data), .inv_fault(inv_fault)
    );

    int checks = 0, errors = 0;
    logic [WW-1:0] model [SL];
    typedef struct { int g; logic [WW-1:0] v; string r; } item_t;
    item_t sb [$];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] pat(int seed, int w);
        logic [WW-1:0] r;
        for (int j = 0; j < 6; j++) r[j*6 +: 6] = 6'(seed * 7 + w * 6 + j * 5 + seed * j);
        return r;
    endfunction

    // Driver side: push the model state of every group into the scoreboard
    task automatic push_all(string req);
        for (int g = 0; g < SL; g++) begin
            item_t it;
            it.g = g; it.v = model[g]; it.r = req;
            sb.push_back(it);
        end
    endtask

    // Monitor side: pop expected groups and compare with the line output
    task automatic drain();
        while (sb.size() > 0) begin
            item_t it = sb.pop_front();
            chk(line_data[it.g*WW +: WW] == it.v, it.r, $sformatf("group %0d", it.g),
                longint'(line_data[it.g*WW +: WW]), longint'(it.v));
        end
    endtask

    task automatic set_start(bit d, bit v);
        if (d) start_r_i = v; else start_l_i = v;
    endtask

    // One full token pass; starts and ends just after a falling edge
    task automatic run_line(bit d, bit inv, int seed, int hold, string req);
        logic fo, fx;
        fill_up = d; inv_en = inv;
        set_start(d, 1'b1);
        @(negedge clk);
        for (int w = 0; w < SL; w++) begin
            if (w >= hold) set_start(d, 1'b0);
            dot_bus = pat(seed, w);
            if (w == SL - 1) begin
                fo = d ? start_l_o : start_r_o;
                chk(fo == 1'b0, "R6", "token before edge 64", longint'(fo), 0);
            end
            @(negedge clk);
        end
        fo = d ? start_l_o : start_r_o;
        fx = d ? start_r_o : start_l_o;
        chk(fo == 1'b1, "R6", "token after edge 64", longint'(fo), 1);
        chk(fx == 1'b0, "R4", "token on input pin", longint'(fx), 0);
        chk(start_l_oe == d && start_r_oe == !d, "R4", "pad enables",
            longint'({start_l_oe, start_r_oe}), longint'({d, !d}));
        dot_bus = '1;
        @(negedge clk);
        fo = d ? start_l_o : start_r_o;
        chk(fo == 1'b0, "R6", "token one cycle only", longint'(fo), 0);
        dot_bus = 36'h5A5A5A5A5;
        @(negedge clk);
        dot_bus = 36'h123456789;
        @(negedge clk);
        dot_bus = '0;
        set_start(d, 1'b0);
        for (int w = 0; w < SL; w++)
            model[d ? w : SL - 1 - w] = pat(seed, w) ^ {WW{inv}};
        push_all(req);
        drain();
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int g = 0; g < SL; g++) model[g] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(line_data == '0, "R1", "line after reset", 0, 0);
        chk(start_l_o == 0 && start_r_o == 0, "R1", "start outs",
            longint'({start_l_o, start_r_o}), 0);
        chk(inv_fault == 0, "R1", "fault flag", longint'(inv_fault), 0);
        @(negedge clk);

        // R2 and R3: both fill orders, R9: inversion
        run_line(1'b1, 1'b0, 1, 0, "R2");
        run_line(1'b0, 1'b0, 2, 0, "R3");
        run_line(1'b1, 1'b1, 3, 0, "R9");
        run_line(1'b0, 1'b1, 4, 0, "R9");

        // R5: start held high for several clocks counts once
        run_line(1'b1, 1'b0, 5, 4, "R5");

        // R4: the unselected start pin has no effect
        fill_up = 1'b1; inv_en = 1'b0;
        start_l_i = 1'b1;
        @(negedge clk);
        start_l_i = 1'b0;
        for (int w = 0; w < 8; w++) begin
            dot_bus = pat(6, w);
            @(negedge clk);
        end
        push_all("R4");
        drain();

        // R7: a later token after the auto-stop still works
        run_line(1'b1, 1'b0, 7, 0, "R7");

        // R8: strobe rise mid-capture rewinds and stops writing
        fill_up = 1'b1;
        start_r_i = 1'b1;
        @(negedge clk);
        start_r_i = 1'b0;
        for (int w = 0; w < 20; w++) begin
            dot_bus = pat(9, w);
            strobe = (w >= 10 && w < 13);
            @(negedge clk);
        end
        strobe = 1'b0;
        for (int w = 0; w < 10; w++) model[w] = pat(9, w);
        push_all("R8");
        drain();
        chk(start_l_o == 0, "R8", "no token after rewind", longint'(start_l_o), 0);

        // R10: inversion change while strobe high
        strobe = 1'b1;
        @(negedge clk);
        inv_en = ~inv_en;
        @(negedge clk);
        chk(inv_fault == 1, "R10", "flag on change", longint'(inv_fault), 1);
        @(negedge clk);
        chk(inv_fault == 0, "R10", "flag clears when stable", longint'(inv_fault), 0);
        strobe = 1'b0;
        @(negedge clk);
        inv_en = ~inv_en;
        @(negedge clk);
        chk(inv_fault == 0, "R10", "no flag with strobe low", longint'(inv_fault), 0);
        push_all("R10");
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule